// File: doc/BRIEF.md
# Bridge Command Register and Forwarding Gate

This block holds the 16-bit command word of a PCI-to-PCI bridge. It answers configuration reads and writes aimed at dword offset 1 (byte offset 04h), with per-byte write enables, and masks every bit the bridge does not implement. Two of the stored bits go straight out as enables for the error-reporting logic that lives elsewhere in the bridge.

The same stored word gates forwarding. The bridge's address decoders present a transaction descriptor: the side it arrived on, memory or I/O space, read or write, the address, and a flag saying whether it falls in the forwarding range for its direction. One cycle later the block returns a registered decision: whether the bridge claims it, whether it is passed across, and whether it is a VGA palette write that is snooped. A snooped write goes across while the primary-side target still takes it.

Top module: `bridge_cmd_ctl`

## Requirements
- R1: After a synchronous reset the command word is 0000h: a read of dword offset 1 returns 0, `serr_en`, `perr_resp_en` and `dec_valid` are low.
- R2: Only bits 0, 1, 2, 5, 6, 8 and 9 can be written (writable mask 0367h). Bits 15 to 10 and bits 7, 4 and 3 always read 0 whatever is written.
- R3: A write to dword offset 1 updates bits 7..0 when `cfg_be[0]` is set and bits 15..8 when `cfg_be[1]` is set; `cfg_be[3:2]` and writes to any other offset change nothing. `cfg_rvalid` pulses one cycle after `cfg_rd`; `cfg_rdata` then holds the command word in bits 15..0 with bits 31..16 zero, or 0 for any other offset.
- R4: Bit 9 reads back as written and changes no forwarding decision.
- R5: `serr_en` follows bit 8 and `perr_resp_en` follows bit 6 of the stored word.
- R6: A primary memory access (`txn_io`=0) with `txn_in_win`=1 is claimed and forwarded exactly when bit 1 is set.
- R7: A primary I/O access (`txn_io`=1) with `txn_in_win`=1 is claimed and forwarded exactly when bit 0 is set.
- R8: A secondary access (`txn_side`=1) is claimed and forwarded exactly when bit 2 is set and `txn_in_win`=1, for memory and I/O alike; bits 0 and 1 do not affect it.
- R9: With bit 5 set, a primary I/O write (`txn_wr`=1) whose address bits 9..0 equal 3C6h, 3C8h or 3C9h gives `dec_snoop`=1 and `dec_fwd`=1 without raising `dec_claim`; reads, memory accesses and secondary accesses are never snooped, and higher address bits are ignored.
- R10: `dec_valid` pulses the cycle after `txn_valid`, with a decision made from the command word as it stood in the `txn_valid` cycle; `dec_claim`, `dec_fwd` and `dec_snoop` are 0 whenever `dec_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_dw_addr | input | CFG_AW | Configuration dword offset |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid with cfg_rvalid |
| cfg_rvalid | output | 1 | Read data valid pulse |
| txn_valid | input | 1 | Descriptor valid strobe |
| txn_side | input | 1 | 0 primary, 1 secondary |
| txn_io | input | 1 | 0 memory space, 1 I/O space |
| txn_wr | input | 1 | 1 write, 0 read |
| txn_addr | input | ADDR_W | Transaction address |
| txn_in_win | input | 1 | Address is in the forwarding range for its direction |
| dec_valid | output | 1 | Decision valid pulse |
| dec_claim | output | 1 | Bridge claims the transaction |
| dec_fwd | output | 1 | Transaction is passed to the other side |
| dec_snoop | output | 1 | Transaction is a snooped palette write |
| serr_en | output | 1 | System error driver enable |
| perr_resp_en | output | 1 | Parity error response enable |

## Verification
The forwarding gate is swept over all 32 settings of the I/O, memory, bus master, snoop and fast back-to-back bits, and under each setting ten descriptors are issued that separate primary memory from primary I/O, in-range from out-of-range, primary from secondary and palette writes from palette reads; this pins each enable to its own direction and space and shows bit 9 changes nothing. A palette sweep with aliased and near-miss addresses tells the 10-bit compare apart from a full or narrower one. Byte-enable and offset patterns separate the two lanes and the masked bits, and a descriptor issued in the same cycle as an enabling write shows the decision uses the old word.

// File: rtl/bridge_cmd_pkg.sv
package bridge_cmd_pkg;
  localparam int CMD_W       = 16;
  localparam int LANES       = CMD_W / 8;
  localparam int CMD_DW_OFF  = 1;
  localparam logic [CMD_W-1:0] CMD_RW_MASK = 16'h0367;

  localparam int B_IO     = 0;
  localparam int B_MEM    = 1;
  localparam int B_MASTER = 2;
  localparam int B_SNOOP  = 5;
  localparam int B_PERR   = 6;
  localparam int B_SERR   = 8;
  localparam int B_FB2B   = 9;

  localparam int PAL_N    = 3;
  localparam int PAL_BITS = 10;
  localparam logic [PAL_N-1:0][PAL_BITS-1:0] PAL_PORTS = {10'h3C9, 10'h3C8, 10'h3C6};

  typedef struct packed {
    logic side;
    logic io;
    logic wr;
    logic in_win;
  } txn_attr_t;

  typedef struct packed {
    logic claim;
    logic fwd;
    logic snoop;
  } fwd_dec_t;
endpackage

// File: rtl/bridge_cmd_regs.sv
module bridge_cmd_regs
  import bridge_cmd_pkg::*;
#(
  parameter int CFG_AW = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [CFG_AW-1:0] cfg_dw_addr,
  input  logic [3:0]        cfg_be,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              cfg_rvalid,
  output logic [CMD_W-1:0]  cmd_q
);
  localparam logic [CFG_AW-1:0] HIT_OFF = CFG_AW'(CMD_DW_OFF);
  localparam int PAD_W = DATA_W - CMD_W;

  logic             hit;
  logic             wr_hit;
  logic [CMD_W-1:0] cmd_d;

  assign hit    = (cfg_dw_addr == HIT_OFF);
  assign wr_hit = cfg_wr && hit;

  always_comb begin
    cmd_d = cmd_q;
    for (int l = 0; l < LANES; l++) begin
      if (wr_hit && cfg_be[l])
        cmd_d[l*8 +: 8] = cfg_wdata[l*8 +: 8] & CMD_RW_MASK[l*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cmd_q <= '0;
    else     cmd_q <= cmd_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rvalid <= 1'b0;
      cfg_rdata  <= '0;
    end else begin
      cfg_rvalid <= cfg_rd;
      cfg_rdata  <= (cfg_rd && hit) ? {{PAD_W{1'b0}}, cmd_q} : '0;
    end
  end
endmodule

// File: rtl/palette_snoop_dec.sv
module palette_snoop_dec
  import bridge_cmd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              pal_hit
);
  logic [PAL_N-1:0] port_eq;

  for (genvar p = 0; p < PAL_N; p++) begin : g_port
    assign port_eq[p] = (addr[PAL_BITS-1:0] == PAL_PORTS[p]);
  end

  assign pal_hit = |port_eq;
endmodule

// File: rtl/fwd_decide.sv
module fwd_decide
  import bridge_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CMD_W-1:0] cmd,
  input  logic             txn_valid,
  input  txn_attr_t        attr,
  input  logic             pal_hit,
  output logic             dec_valid,
  output fwd_dec_t         dec
);
  logic     prim;
  logic     prim_ok;
  fwd_dec_t dec_d;

  assign prim    = !attr.side;
  assign prim_ok = attr.io ? cmd[B_IO] : cmd[B_MEM];

  always_comb begin
    dec_d.claim = attr.in_win && (prim ? prim_ok : cmd[B_MASTER]);
    dec_d.snoop = prim && attr.io && attr.wr && cmd[B_SNOOP] && pal_hit;
    dec_d.fwd   = dec_d.claim || dec_d.snoop;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      dec       <= '0;
    end else begin
      dec_valid <= txn_valid;
      dec       <= txn_valid ? dec_d : '0;
    end
  end
endmodule

// File: rtl/bridge_cmd_ctl.sv
module bridge_cmd_ctl
  import bridge_cmd_pkg::*;
#(
  parameter int CFG_AW = 6,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [CFG_AW-1:0] cfg_dw_addr,
  input  logic [3:0]        cfg_be,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              cfg_rvalid,
  input  logic              txn_valid,
  input  logic              txn_side,
  input  logic              txn_io,
  input  logic              txn_wr,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic              txn_in_win,
  output logic              dec_valid,
  output logic              dec_claim,
  output logic              dec_fwd,
  output logic              dec_snoop,
  output logic              serr_en,
  output logic              perr_resp_en
);
  logic [CMD_W-1:0] cmd_q;
  logic             pal_hit;
  txn_attr_t        attr;
  fwd_dec_t         dec;

  assign attr = '{side: txn_side, io: txn_io, wr: txn_wr, in_win: txn_in_win};

  bridge_cmd_regs #(.CFG_AW(CFG_AW), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_dw_addr(cfg_dw_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
    .cmd_q(cmd_q)
  );

  palette_snoop_dec #(.ADDR_W(ADDR_W)) u_pal (
    .addr(txn_addr), .pal_hit(pal_hit)
  );

  fwd_decide u_dec (
    .clk(clk), .rst(rst), .cmd(cmd_q),
    .txn_valid(txn_valid), .attr(attr), .pal_hit(pal_hit),
    .dec_valid(dec_valid), .dec(dec)
  );

  assign dec_claim    = dec.claim;
  assign dec_fwd      = dec.fwd;
  assign dec_snoop    = dec.snoop;
  assign serr_en      = cmd_q[B_SERR];
  assign perr_resp_en = cmd_q[B_PERR];
endmodule

// File: rtl/bridge_cmd_ctl_chk.sv
module bridge_cmd_ctl_chk
  import bridge_cmd_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             cfg_wr,
  input logic [3:0]       cfg_be,
  input logic [31:0]      cfg_rdata,
  input logic             cfg_rvalid,
  input logic             txn_valid,
  input logic             txn_side,
  input logic             txn_io,
  input logic             txn_wr,
  input logic             dec_valid,
  input logic             dec_claim,
  input logic             dec_fwd,
  input logic             dec_snoop,
  input logic             serr_en,
  input logic [CMD_W-1:0] cmd_q
);
  // R2: masked bits never appear on a read
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_rvalid |-> (cfg_rdata[15:10] == 6'd0 && cfg_rdata[7] == 1'b0 &&
                    cfg_rdata[4] == 1'b0 && cfg_rdata[3] == 1'b0));

  // R5: the error enable only moves after a write with the upper lane enabled
  assert_serr_move_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(serr_en) |-> ($past(rst) || ($past(cfg_wr) && $past(cfg_be[1]))));

  // R10: one decision pulse per descriptor, one cycle later
  assert_dec_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (dec_valid == $past(txn_valid)));

  // R10: outputs quiet between decisions
  assert_dec_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> !(dec_claim || dec_fwd || dec_snoop));

  // R6: a claim always goes across
  assert_claim_fwd_R6: assert property (@(posedge clk) disable iff (rst)
    dec_claim |-> dec_fwd);

  // R8: secondary traffic is never taken with bus mastering off
  assert_sec_master_R8: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && $past(txn_side) && !$past(cmd_q[B_MASTER])) |-> !(dec_claim || dec_fwd));

  // R9: snoop only on primary I/O writes
  assert_snoop_kind_R9: assert property (@(posedge clk) disable iff (rst)
    dec_snoop |-> (dec_fwd && !$past(txn_side) && $past(txn_io) && $past(txn_wr)));
endmodule

bind bridge_cmd_ctl bridge_cmd_ctl_chk u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
  .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
  .txn_valid(txn_valid), .txn_side(txn_side), .txn_io(txn_io), .txn_wr(txn_wr),
  .dec_valid(dec_valid), .dec_claim(dec_claim), .dec_fwd(dec_fwd),
  .dec_snoop(dec_snoop), .serr_en(serr_en), .cmd_q(cmd_q)
);

// File: tb/bridge_cmd_ctl_test.sv
module bridge_cmd_ctl_test;
  localparam int CFG_AW = 6;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [CFG_AW-1:0] cfg_dw_addr = '0;
  logic [3:0]        cfg_be = '0;
  logic [31:0]       cfg_wdata = '0;
  logic [31:0]       cfg_rdata;
  logic              cfg_rvalid;
  logic              txn_valid = 1'b0, txn_side = 1'b0, txn_io = 1'b0, txn_wr = 1'b0;
  logic [ADDR_W-1:0] txn_addr = '0;
  logic              txn_in_win = 1'b0;
  logic              dec_valid, dec_claim, dec_fwd, dec_snoop, serr_en, perr_resp_en;

  int checks = 0;
  int fails  = 0;
  logic [15:0] cmd_m;

  always #2 clk = ~clk;

  bridge_cmd_ctl #(.CFG_AW(CFG_AW), .ADDR_W(ADDR_W), .DATA_W(32)) uut (
    .clk(clk), .rst(rst),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_dw_addr(cfg_dw_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
    .txn_valid(txn_valid), .txn_side(txn_side), .txn_io(txn_io), .txn_wr(txn_wr),
    .txn_addr(txn_addr), .txn_in_win(txn_in_win),
    .dec_valid(dec_valid), .dec_claim(dec_claim), .dec_fwd(dec_fwd),
    .dec_snoop(dec_snoop), .serr_en(serr_en), .perr_resp_en(perr_resp_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    cmd_m = 16'h0000;
  endtask

  task automatic cfg_write(input logic [CFG_AW-1:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_dw_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
    if (a == CFG_AW'(1)) begin
      for (int l = 0; l < 2; l++)
        if (be[l]) cmd_m[l*8 +: 8] = d[l*8 +: 8] & (l == 0 ? 8'h67 : 8'h03);
    end
  endtask

  task automatic cfg_read(input logic [CFG_AW-1:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_dw_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0;
    d = cfg_rdata; v = cfg_rvalid;
  endtask

  function automatic logic [3:0] exp_dec(input logic side, input logic io, input logic wr,
                                          input logic [ADDR_W-1:0] addr, input logic win);
    logic claim, snoop, pal;
    pal   = (addr[9:0] == 10'h3C6) || (addr[9:0] == 10'h3C8) || (addr[9:0] == 10'h3C9);
    if (side == 1'b0) claim = win && (io ? cmd_m[0] : cmd_m[1]);
    else              claim = win && cmd_m[2];
    snoop = (side == 1'b0) && io && wr && cmd_m[5] && pal;
    return {1'b1, claim, claim || snoop, snoop};
  endfunction

  task automatic send_txn(input logic side, input logic io, input logic wr,
                          input logic [ADDR_W-1:0] addr, input logic win,
                          output logic [3:0] got);
    @(negedge clk);
    txn_valid = 1'b1; txn_side = side; txn_io = io; txn_wr = wr;
    txn_addr = addr; txn_in_win = win;
    @(negedge clk);
    txn_valid = 1'b0;
    got = {dec_valid, dec_claim, dec_fwd, dec_snoop};
  endtask

  task automatic t_reset_state();
    logic [31:0] d; logic v;
    cfg_read(CFG_AW'(1), d, v);
    check("R1 reset read", d, 32'h0);
    check("R1 reset rvalid", {31'd0, v}, 32'd1);
    check("R1 reset enables", {30'd0, serr_en, perr_resp_en}, 32'd0);
    check("R1 reset dec_valid", {31'd0, dec_valid}, 32'd0);
  endtask

  task automatic t_masks_and_lanes();
    logic [31:0] d; logic v;
    cfg_write(CFG_AW'(1), 4'b1111, 32'hFFFF_FFFF);
    cfg_read(CFG_AW'(1), d, v);
    check("R2 writable mask", d, 32'h0000_0367);
    cfg_write(CFG_AW'(1), 4'b1100, 32'h0);
    cfg_read(CFG_AW'(1), d, v);
    check("R3 upper enables ignored", d, 32'h0000_0367);
    cfg_write(CFG_AW'(1), 4'b0001, 32'h0);
    cfg_read(CFG_AW'(1), d, v);
    check("R3 low lane only", d, 32'h0000_0300);
    cfg_write(CFG_AW'(1), 4'b0010, 32'h0000_00FF);
    cfg_read(CFG_AW'(1), d, v);
    check("R3 high lane only", d, 32'h0000_0000);
    cfg_write(CFG_AW'(1), 4'b0001, 32'h0000_FFFF);
    cfg_read(CFG_AW'(1), d, v);
    check("R2 low lane mask", d, 32'h0000_0067);
    cfg_write(CFG_AW'(2), 4'b1111, 32'h0);
    cfg_write(CFG_AW'(0), 4'b1111, 32'h0);
    cfg_read(CFG_AW'(1), d, v);
    check("R3 other offset write ignored", d, 32'h0000_0067);
    cfg_read(CFG_AW'(0), d, v);
    check("R3 other offset reads zero", d, 32'h0);
    check("R3 rvalid pulse", {31'd0, v}, 32'd1);
    @(negedge clk);
    check("R3 rvalid single cycle", {31'd0, cfg_rvalid}, 32'd0);
  endtask

  task automatic t_err_enables();
    cfg_write(CFG_AW'(1), 4'b0011, 32'h0000_0100);
    check("R5 serr set", {30'd0, serr_en, perr_resp_en}, 32'd2);
    cfg_write(CFG_AW'(1), 4'b0011, 32'h0000_0040);
    check("R5 perr set", {30'd0, serr_en, perr_resp_en}, 32'd1);
    cfg_write(CFG_AW'(1), 4'b0011, 32'h0000_0000);
    check("R5 both clear", {30'd0, serr_en, perr_resp_en}, 32'd0);
  endtask

  task automatic t_enable_sweep();
    logic [31:0] d; logic v; logic [3:0] got;
    logic side, io, wr, win; logic [ADDR_W-1:0] a;
    for (int m = 0; m < 32; m++) begin
      cfg_write(CFG_AW'(1), 4'b0011,
                {22'd0, m[4], 3'd0, m[3], 2'd0, m[2], m[1], m[0]});
      cfg_read(CFG_AW'(1), d, v);
      check("R4 readback incl bit9", d, {16'd0, cmd_m});
      for (int k = 0; k < 10; k++) begin
        case (k)
          0: begin side = 0; io = 0; wr = 0; a = 32'h0000_1000; win = 1; end // R6
          1: begin side = 0; io = 0; wr = 1; a = 32'h0000_2000; win = 0; end // R6
          2: begin side = 0; io = 1; wr = 0; a = 32'h0000_0300; win = 1; end // R7
          3: begin side = 0; io = 1; wr = 1; a = 32'h0000_03C8; win = 1; end // R7 R9
          4: begin side = 0; io = 1; wr = 1; a = 32'h0000_FBC6; win = 0; end // R9
          5: begin side = 0; io = 1; wr = 0; a = 32'h0000_03C9; win = 0; end // R9
          6: begin side = 1; io = 0; wr = 1; a = 32'h0000_4000; win = 1; end // R8
          7: begin side = 1; io = 1; wr = 0; a = 32'h0000_0310; win = 1; end // R8
          8: begin side = 1; io = 1; wr = 1; a = 32'h0000_03C6; win = 0; end // R8 R9
          default: begin side = 0; io = 0; wr = 1; a = 32'h0000_03C6; win = 0; end // R9
        endcase
        send_txn(side, io, wr, a, win, got);
        check("R4 R6 R7 R8 R9 decision", {28'd0, got}, {28'd0, exp_dec(side, io, wr, a, win)});
      end
    end
  endtask

  task automatic t_palette_alias();
    logic [3:0] got;
    logic [ADDR_W-1:0] a;
    cfg_write(CFG_AW'(1), 4'b0011, 32'h0000_0020);
    for (int k = 0; k < 10; k++) begin
      case (k)
        0: a = 32'h0000_03C6;
        1: a = 32'h0000_03C8;
        2: a = 32'h0000_03C9;
        3: a = 32'h0000_07C8;
        4: a = 32'hABCD_13C9;
        5: a = 32'h0000_03C7;
        6: a = 32'h0000_03C5;
        7: a = 32'h0000_03CA;
        8: a = 32'h0000_02C6;
        default: a = 32'h0000_01C8;
      endcase
      send_txn(1'b0, 1'b1, 1'b1, a, 1'b0, got);
      check("R9 palette alias decode", {28'd0, got}, {28'd0, exp_dec(1'b0, 1'b1, 1'b1, a, 1'b0)});
    end
  endtask

  task automatic t_decision_timing();
    logic [3:0] got;
    cfg_write(CFG_AW'(1), 4'b0011, 32'h0);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_dw_addr = CFG_AW'(1); cfg_be = 4'b0001; cfg_wdata = 32'h2;
    txn_valid = 1'b1; txn_side = 1'b0; txn_io = 1'b0; txn_wr = 1'b0;
    txn_addr = 32'h1000; txn_in_win = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; txn_valid = 1'b0; cmd_m = 16'h0002;
    check("R10 uses old word", {28'd0, dec_valid, dec_claim, dec_fwd, dec_snoop}, 32'h8);
    @(negedge clk);
    check("R10 pulse ends", {28'd0, dec_valid, dec_claim, dec_fwd, dec_snoop}, 32'h0);
    send_txn(1'b0, 1'b0, 1'b0, 32'h1000, 1'b1, got);
    check("R10 R6 new word applies", {28'd0, got}, 32'hE);
  endtask

  task automatic t_reset_again();
    logic [31:0] d; logic v;
    cfg_write(CFG_AW'(1), 4'b0011, 32'hFFFF);
    do_reset();
    cfg_read(CFG_AW'(1), d, v);
    check("R1 reset clears word", d, 32'h0);
    check("R1 reset clears enables", {30'd0, serr_en, perr_resp_en}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    do_reset();
    t_reset_state();
    t_masks_and_lanes();
    t_err_enables();
    t_enable_sweep();
    t_palette_alias();
    t_decision_timing();
    t_reset_again();
    summary();
  end
endmodule